// File: doc/BRIEF.md
# Load Switch Fault Supervisor

This block is the digital supervisor for one channel of a high-side load switch. It watches five comparator flags: current limit, relative over-temperature, absolute over-temperature, thermal hysteresis met, and output near supply while the switch is off. Before any flag can act, it must stay asserted for a minimum time, and each fault type has its own minimum. Once a fault is accepted, the block regulates at the current limit, shuts the channel down, retries the channel, or latches it off.

The block drives five things:
- the power-stage gate enable;
- a current-regulation request;
- an open-drain fault output and its tristate control;
- a select for the sense pin;
- a pull-up enable for the output while the switch is off.

A diagnostic-enable input silences the two reporting outputs. Protection keeps running while the reporting outputs are silenced.

The supervisor is a five-state machine:
- `ST_OFF`: the channel is disabled.
- `ST_ON`: the channel conducts.
- `ST_LIMIT`: the channel conducts and requests current regulation.
- `ST_COOL`: thermal shutdown with automatic retry.
- `ST_LATCHED`: thermal shutdown held off.

The transitions are:
- **enable**: `ST_OFF`→`ST_ON` when enable is high.
- **disable**: `ST_ON`, `ST_LIMIT` or `ST_COOL` → `ST_OFF` when enable is low.
- **overcurrent**: `ST_ON`→`ST_LIMIT`.
- **limit release**: `ST_LIMIT`→`ST_ON`.
- **shutdown**: `ST_ON` or `ST_LIMIT` → `ST_COOL` when the latch pin is low, or → `ST_LATCHED` when it is high.
- **retry**: `ST_COOL`→`ST_ON`.
- **unlatch**: `ST_LATCHED`→`ST_OFF`. Enable then re-arms the channel through the enable transition.

Top module: `lsw_fault_supervisor`

## Requirements
- R1: Each flag must be high for a set number of consecutive clocks before it counts. The number is TICKS_PER_US × tenths-of-µs / 10. The defaults are 2.5 µs for current limit, 2.5 µs for relative temperature, 20 µs for absolute temperature and 500 µs for open load. With TICKS_PER_US=10 these give 25, 25, 200 and 5000 clocks. A flag that drops resets its count.
- R2: While the channel is on, an accepted current-limit flag has these effects:
  - the gate stays on and `ilim_req_o` goes to 1;
  - the fault output is driven low;
  - the sense select reads FAULT.
  The channel returns to normal once the flag clears.
- R3: An accepted relative or absolute temperature flag turns the gate off within one clock, drives the fault output low and selects FAULT on the sense pin. It takes priority over current limit, and `ilim_req_o` drops.
- R4: With the latch pin low, a thermal shutdown restarts the channel only when both of these are true: RETRY_CYC clocks have passed since shutdown, and the hysteresis flag is high.
- R5: With the latch pin high, a thermal shutdown keeps the gate off regardless of hysteresis or elapsed time. It ends only on an edge of the latch pin or the enable pin, after synchronization, seen while both raw temperature flags are low.
- R6: While enable is low, the pull-up is on, and an accepted open-load flag drives the fault output low and selects FAULT on the sense pin. The report clears by itself when the flag drops. An open-load flag is ignored while the channel is on.
- R7: The sense select encoding is HIZ=00, ZERO=01, LOAD=10, FAULT=11. With no fault, the block shows LOAD when on and ZERO when off, and `flt_oe_o`=0.
- R8: When `diag_en_i` is low, `flt_oe_o`=0 and the sense select is HIZ. Gate control and current regulation behave exactly as with diagnostics enabled.
- R9: After reset the gate is off, `ilim_req_o`=0, the pull-up is on, `flt_oe_o`=0 and the sense select is ZERO with diagnostics enabled. Enable and latch pass through two synchronizer flops, so the gate follows enable three clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_i | input | 1 | Channel enable pin (asynchronous) |
| latch_i | input | 1 | Thermal latch-off mode pin (asynchronous) |
| diag_en_i | input | 1 | Diagnostics enable |
| ilim_flag_i | input | 1 | Current at limit comparator |
| trel_flag_i | input | 1 | Relative over-temperature comparator |
| tabs_flag_i | input | 1 | Absolute over-temperature comparator |
| hyst_ok_i | input | 1 | Temperature back below hysteresis |
| ol_flag_i | input | 1 | Output near supply while off |
| gate_on_o | output | 1 | Power-stage gate enable |
| ilim_req_o | output | 1 | Current regulation request |
| flt_o | output | 1 | Fault pin value (0 when faulted) |
| flt_oe_o | output | 1 | Fault pin driver enable (open drain) |
| sns_sel_o | output | 2 | Sense pin source select |
| pullup_en_o | output | 1 | Off-state output pull-up enable |

## Verification
The hardest states to reach from the ports are the two thermal-shutdown states. Both need a temperature flag held through its full window. The auto-retry state must also be held across the retry interval while hysteresis is toggled, so that each gating condition is seen failing on its own. The bench waits for the gate to fall, counts clocks from that point, and changes the hysteresis input on either side of the retry boundary. For the latched state, a latch-pin edge is first made while the temperature flag is still high and must not release the channel. A second edge after the flag clears does release it.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_ON,
        ST_LIMIT,
        ST_COOL,
        ST_LATCHED
    } lsw_state_e;

    typedef enum logic [1:0] {
        SNS_HIZ   = 2'b00,
        SNS_ZERO  = 2'b01,
        SNS_LOAD  = 2'b10,
        SNS_FAULT = 2'b11
    } sns_sel_e;

    localparam int unsigned NFLAG  = 4;
    localparam int unsigned F_ILIM = 0;
    localparam int unsigned F_TREL = 1;
    localparam int unsigned F_TABS = 2;
    localparam int unsigned F_OL   = 3;
endpackage

// File: rtl/lsw_sync2.sv
module lsw_sync2 #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q_o  <= '0;
        end else begin
            meta <= d_i;
            q_o  <= meta;
        end
    end
endmodule

// File: rtl/lsw_deglitch.sv
module lsw_deglitch #(
    parameter int unsigned CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_i,
    output logic qual_o
);
    localparam int unsigned W = $clog2(CYCLES + 1);
    localparam logic [W-1:0] LIM = W'(CYCLES);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!flag_i) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qual_o = (cnt == LIM);

    AST_DG_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual_o) |-> $past(flag_i)); // R1
endmodule

// File: rtl/lsw_fault_supervisor.sv
module lsw_fault_supervisor
    import lsw_pkg::*;
#(
    parameter int unsigned TICKS_PER_US = 10,
    parameter int unsigned ILIM_X10     = 25,
    parameter int unsigned TREL_X10     = 25,
    parameter int unsigned TABS_X10     = 200,
    parameter int unsigned OL_X10       = 5000,
    parameter int unsigned RETRY_CYC    = 3000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       latch_i,
    input  logic       diag_en_i,
    input  logic       ilim_flag_i,
    input  logic       trel_flag_i,
    input  logic       tabs_flag_i,
    input  logic       hyst_ok_i,
    input  logic       ol_flag_i,
    output logic       gate_on_o,
    output logic       ilim_req_o,
    output logic       flt_o,
    output logic       flt_oe_o,
    output logic [1:0] sns_sel_o,
    output logic       pullup_en_o
);
    localparam int unsigned DG_X10 [NFLAG] = '{ILIM_X10, TREL_X10, TABS_X10, OL_X10};
    localparam int unsigned RW = $clog2(RETRY_CYC + 1);
    localparam logic [RW-1:0] RLIM = RW'(RETRY_CYC);

    // pin synchronization and edge detection
    logic [1:0] pins_s, pins_d;
    logic       en_s, latch_s, toggle;

    lsw_sync2 #(.WIDTH(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({latch_i, en_i}),
        .q_o  (pins_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins_d <= '0;
        else        pins_d <= pins_s;
    end

    assign en_s    = pins_s[0];
    assign latch_s = pins_s[1];
    assign toggle  = |(pins_s ^ pins_d);

    // per-fault deglitch filters
    logic [NFLAG-1:0] raw, qual;
    assign raw = {ol_flag_i, tabs_flag_i, trel_flag_i, ilim_flag_i};

    for (genvar g = 0; g < NFLAG; g++) begin : g_dg
        lsw_deglitch #(.CYCLES(TICKS_PER_US * DG_X10[g] / 10)) u_dg (
            .clk   (clk),
            .rst_n (rst_n),
            .flag_i(raw[g]),
            .qual_o(qual[g])
        );
    end

    logic tsd_q, ilim_q, ol_q, hot_raw;
    assign tsd_q   = qual[F_TREL] | qual[F_TABS];
    assign ilim_q  = qual[F_ILIM];
    assign ol_q    = qual[F_OL];
    assign hot_raw = raw[F_TREL] | raw[F_TABS];

    // state register and retry timer
    lsw_state_e    state, state_nx;
    logic [RW-1:0] retry_cnt;
    logic          retry_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 retry_cnt <= '0;
        else if (state != ST_COOL)  retry_cnt <= '0;
        else if (retry_cnt != RLIM) retry_cnt <= retry_cnt + 1'b1;
    end

    assign retry_done = (retry_cnt == RLIM);

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (en_s) state_nx = ST_ON;
            end
            ST_ON, ST_LIMIT: begin
                if (!en_s)       state_nx = ST_OFF;
                else if (tsd_q)  state_nx = latch_s ? ST_LATCHED : ST_COOL;
                else if (ilim_q) state_nx = ST_LIMIT;
                else             state_nx = ST_ON;
            end
            ST_COOL: begin
                if (!en_s)                         state_nx = ST_OFF;
                else if (retry_done && hyst_ok_i)  state_nx = ST_ON;
            end
            ST_LATCHED: begin
                if (toggle && !hot_raw) state_nx = ST_OFF;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // outputs
    logic     fault;
    sns_sel_e sns;

    always_comb begin
        gate_on_o   = 1'b0;
        ilim_req_o  = 1'b0;
        pullup_en_o = 1'b0;
        fault       = 1'b0;
        sns         = SNS_ZERO;
        unique case (state)
            ST_OFF: begin
                pullup_en_o = 1'b1;
                fault       = ol_q;
                sns         = ol_q ? SNS_FAULT : SNS_ZERO;
            end
            ST_ON: begin
                gate_on_o = 1'b1;
                sns       = SNS_LOAD;
            end
            ST_LIMIT: begin
                gate_on_o  = 1'b1;
                ilim_req_o = 1'b1;
                fault      = 1'b1;
                sns        = SNS_FAULT;
            end
            ST_COOL, ST_LATCHED: begin
                fault = 1'b1;
                sns   = SNS_FAULT;
            end
            default: ;
        endcase
        flt_o     = !fault;
        flt_oe_o  = diag_en_i & fault;
        sns_sel_o = diag_en_i ? sns : SNS_HIZ;
    end

    AST_LIMIT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON && ilim_q && !tsd_q && en_s) |=> ilim_req_o); // R2
    AST_SHUTDOWN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on_o && tsd_q) |=> !gate_on_o); // R3
    AST_RETRY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COOL && !retry_done) |=> !gate_on_o); // R4
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCHED && !toggle) |=> (state == ST_LATCHED)); // R5
    AST_DIAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !diag_en_i |-> (!flt_oe_o && sns_sel_o == SNS_HIZ)); // R8
endmodule

// File: tb/sim_lsw_fault_supervisor.sv
module sim_lsw_fault_supervisor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 0, latch = 0, diag = 1, ilim = 0, trel = 0, tabs = 0, hyst = 0, ol = 0;
    logic gate, ireq, flt, flt_oe, pull;
    logic [1:0] sns;
    int n_chk = 0, n_bad = 0;

    localparam logic [1:0] HIZ = 2'b00, ZERO = 2'b01, LOAD = 2'b10, FAULT = 2'b11;

    always #5 clk = ~clk;

    lsw_fault_supervisor u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en), .latch_i(latch), .diag_en_i(diag),
        .ilim_flag_i(ilim), .trel_flag_i(trel), .tabs_flag_i(tabs), .hyst_ok_i(hyst),
        .ol_flag_i(ol), .gate_on_o(gate), .ilim_req_o(ireq), .flt_o(flt),
        .flt_oe_o(flt_oe), .sns_sel_o(sns), .pullup_en_o(pull)
    );

    task automatic chk(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        wait_n(1);
        chk("R9", "gate", gate, 0);
        chk("R9", "ilim_req", ireq, 0);
        chk("R9", "pullup", pull, 1);
        chk("R9", "flt_oe", flt_oe, 0);
        chk("R9", "sns", sns, ZERO);
        rst_n = 1'b1;
        wait_n(2);
        en = 1;
        wait_n(2);
        chk("R9", "gate before sync", gate, 0);
        wait_n(1);
        chk("R9", "gate after sync", gate, 1);
    endtask

    task automatic t_normal();
        wait_n(5);
        chk("R7", "gate on", gate, 1);
        chk("R7", "flt_oe on", flt_oe, 0);
        chk("R7", "sns on", sns, LOAD);
        chk("R6", "pullup on", pull, 0);
        ol = 1;
        wait_n(5100);
        chk("R6", "ol ignored while on", flt_oe, 0);
        en = 0;
        wait_n(5);
        chk("R6", "ol reported off", flt_oe, 1);
        chk("R6", "ol sns", sns, FAULT);
        chk("R6", "ol flt pin", flt, 0);
        ol = 0;
        wait_n(3);
        chk("R6", "ol self clear", flt_oe, 0);
        chk("R7", "sns off", sns, ZERO);
    endtask

    task automatic t_ol_boundary();
        ol = 1;
        repeat (4999) @(posedge clk);
        @(negedge clk);
        chk("R1", "ol at 4999", flt_oe, 0);
        @(negedge clk);
        chk("R1", "ol at 5000", flt_oe, 1);
        chk("R6", "pullup off-state", pull, 1);
        ol = 0;
        wait_n(3);
    endtask

    task automatic t_ilim();
        en = 1;
        wait_n(6);
        ilim = 1;
        wait_n(20);
        ilim = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (i == 29) chk("R1", "short ilim pulse", ireq, 0);
        end
        ilim = 1;
        repeat (25) @(posedge clk);
        @(negedge clk);
        chk("R1", "ilim at 25", ireq, 0);
        @(negedge clk);
        chk("R2", "ilim req", ireq, 1);
        chk("R2", "gate stays", gate, 1);
        chk("R2", "flt_oe", flt_oe, 1);
        chk("R2", "sns", sns, FAULT);
        ilim = 0;
        wait_n(3);
        chk("R2", "release", ireq, 0);
        chk("R2", "release sns", sns, LOAD);
    endtask

    task automatic t_priority();
        ilim = 1;
        wait_n(30);
        chk("R2", "limit before tsd", ireq, 1);
        trel = 1;
        wait_n(30);
        chk("R3", "gate off", gate, 0);
        chk("R3", "req dropped", ireq, 0);
        chk("R3", "flt_oe", flt_oe, 1);
        chk("R3", "sns", sns, FAULT);
        ilim = 0; trel = 0; hyst = 1;
        wait_n(3100);
        chk("R4", "retry back on", gate, 1);
    endtask

    task automatic t_retry();
        hyst = 1;
        tabs = 1;
        for (int i = 0; i < 400 && gate; i++) @(negedge clk);
        chk("R3", "tabs shutdown", gate, 0);
        tabs = 0;
        wait_n(2899);
        chk("R4", "hyst ok but timer running", gate, 0);
        hyst = 0;
        wait_n(600);
        chk("R4", "timer done but no hyst", gate, 0);
        hyst = 1;
        wait_n(3);
        chk("R4", "both met", gate, 1);
    endtask

    task automatic t_latch();
        latch = 1;
        wait_n(6);
        trel = 1;
        wait_n(40);
        chk("R5", "latched off", gate, 0);
        latch = 0;
        wait_n(10);
        chk("R5", "toggle while hot", gate, 0);
        trel = 0; hyst = 1;
        wait_n(4000);
        chk("R5", "held after retry time", gate, 0);
        latch = 1;
        wait_n(10);
        chk("R5", "unlatched", gate, 1);
    endtask

    task automatic t_diag();
        diag = 0;
        ilim = 1;
        wait_n(30);
        chk("R8", "gate", gate, 1);
        chk("R8", "ilim req", ireq, 1);
        chk("R8", "flt_oe", flt_oe, 0);
        chk("R8", "sns", sns, HIZ);
        ilim = 0;
        en = 0;
        wait_n(6);
        chk("R8", "sns off", sns, HIZ);
        chk("R8", "gate off", gate, 0);
        diag = 1;
        wait_n(1);
        chk("R8", "sns restored", sns, ZERO);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_ol_boundary();
        t_ilim();
        t_priority();
        t_retry();
        t_latch();
        t_diag();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule